// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block recovers characters from an asynchronous serial line. The line is held at mark (logic 1) while idle. Each character opens with a space (logic 0) start bit, carries 5 to 8 data bits least significant first, may carry a parity bit, and closes with one or two stop bits at mark. A free-running enable `tick` marks the receiver's time base at sixteen pulses per bit. This base may come from a different source than the one feeding the far-end transmitter. The serial input passes through a two-stage synchronizer before any decision is taken on it.

Once a character is complete, the data is presented right-aligned and a data-available flag rises. A consumer drops `ack_n` low to clear the flag. If a newer character completes while the flag is still up, the overrun flag is raised and the newer data replaces the old. Parity, framing and overrun flags are recomputed at the end of every character. The data outputs float while `data_oe_n` is high, and the three error outputs float while `stat_oe_n` is high. The format controls are static and must be changed only while the line is idle.

Top module: `async_rx`

## Requirements
- R1: After reset, `data_avail`, `par_err`, `frm_err` and `ovr_err` read 0 and `rdata` reads 0.
- R2: A character begins only when a tick sees the synchronized line at space and the previous tick saw it at mark. On the 8th tick after that, the line is sampled again. If it is back at mark, the attempt is dropped and no output changes.
- R3: Data bits are sampled every 16 ticks, least significant bit first. The data width is 5 + `cfg_len` (00 gives 5 bits, 11 gives 8). `rdata` is right-aligned with the unused upper bits at 0.
- R4: With `cfg_par_off`=0, one parity bit follows the data. `cfg_par_even`=1 selects even parity (data plus parity holds an even count of ones) and 0 selects odd parity. `par_err` is 1 when the received count does not match. With `cfg_par_off`=1, `par_err` is 0.
- R5: The stop bit is sampled 16 ticks after the last data or parity bit. With `cfg_two_stop`=1, a second stop bit is sampled 16 ticks later. `frm_err` is 1 when any sampled stop bit is at space.
- R6: Call the first tick that falls on or after the third rising clock edge following the line's fall the detection tick. Results update on the clock edge of the tick that comes 8 + 16*(B-1) ticks after the detection tick, where B counts every bit of the character including start and stop bits.
- R7: `data_avail` goes to 1 when a character completes. It goes to 0 on any clock edge where `ack_n` is low and no character completes on that edge.
- R8: `ovr_err` is set at completion when `data_avail` was still 1 and `ack_n` was high on that edge. It is cleared at a completion where either condition fails.
- R9: `rdata`, `par_err`, `frm_err` and `ovr_err` change only at character completion, and all four are replaced together. A dropped start leaves them unchanged.
- R10: `rdata` is high impedance while `data_oe_n`=1. The three error outputs are high impedance while `stat_oe_n`=1. `data_avail` is always driven.
- R11: The receiver's state advances only on clock edges where `tick` is 1, so any tick spacing works.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Enable at 16 pulses per bit |
| rx_line | input | 1 | Asynchronous serial input, mark = 1 |
| cfg_len | input | 2 | Data width minus 5 |
| cfg_par_off | input | 1 | 1 = no parity bit |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| ack_n | input | 1 | Low level clears data_avail |
| data_oe_n | input | 1 | Low drives rdata |
| stat_oe_n | input | 1 | Low drives the error flags |
| rdata | output | 8 | Received character, right-aligned |
| data_avail | output | 1 | Character waiting |
| par_err | output | 1 | Parity mismatch on last character |
| frm_err | output | 1 | Stop bit at space on last character |
| ovr_err | output | 1 | Last character overwrote an unread one |

## Verification
A bit counter or tick counter that is off by one moves the completion edge. The bench predicts that edge from R6 alone, so the error shows within the same character as a data_avail mismatch. A wrong shift, width decode or parity accumulator shows in rdata or par_err on the first character that completes. A stuck or miscleared data-available state shows in ovr_err one character later, when the next character completes. The reference model is compared on every clock, so each of these is caught on the first clock where it differs.

// File: rtl/async_rx.sv
module async_rx #(
  parameter int OVS  = 16,
  parameter int MAXW = 8,
  parameter int MINW = 5,
  parameter int SYNC = 2,
  localparam int LW  = $clog2(MAXW - MINW + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            rx_line,
  input  logic [LW-1:0]   cfg_len,
  input  logic            cfg_par_off,
  input  logic            cfg_par_even,
  input  logic            cfg_two_stop,
  input  logic            ack_n,
  input  logic            data_oe_n,
  input  logic            stat_oe_n,
  output logic [MAXW-1:0] rdata,
  output logic            data_avail,
  output logic            par_err,
  output logic            frm_err,
  output logic            ovr_err
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(MAXW + 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_START = 3'd1, S_DATA = 3'd2,
                         S_PAR = 3'd3, S_STOP = 3'd4, S_STOP2 = 3'd5;

  logic [SYNC-1:0] sy;
  logic            rx_s, seen_hi, acc, fe_acc;
  logic [2:0]      st;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn, nbits;
  logic [MAXW-1:0] sh, data_q;
  logic            da_q, pe_q, fe_q, ovr_q;
  logic            last, half, done;

  assign rx_s  = sy[SYNC-1];
  assign nbits = BW'(MINW) + BW'(cfg_len);
  assign last  = (cnt == CW'(OVS - 1));
  assign half  = (cnt == CW'(OVS / 2 - 1));
  assign done  = tick && last && ((st == S_STOP && !cfg_two_stop) || st == S_STOP2);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sy <= '1;
    else        sy <= {sy[SYNC-2:0], rx_line};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      sh      <= '0;
      acc     <= 1'b0;
      fe_acc  <= 1'b0;
      seen_hi <= 1'b0;
    end else if (tick) begin
      case (st)
        S_IDLE: begin
          seen_hi <= rx_s;
          if (seen_hi && !rx_s) begin
            st  <= S_START;
            cnt <= '0;
          end
        end
        S_START: begin
          if (half) begin
            cnt <= '0;
            if (rx_s) begin
              st      <= S_IDLE;
              seen_hi <= 1'b1;
            end else begin
              st     <= S_DATA;
              bitn   <= '0;
              acc    <= 1'b0;
              fe_acc <= 1'b0;
            end
          end else cnt <= cnt + CW'(1);
        end
        S_DATA: begin
          if (last) begin
            cnt  <= '0;
            sh   <= {rx_s, sh[MAXW-1:1]};
            acc  <= acc ^ rx_s;
            bitn <= bitn + BW'(1);
            if (bitn == nbits - BW'(1)) st <= cfg_par_off ? S_STOP : S_PAR;
          end else cnt <= cnt + CW'(1);
        end
        S_PAR: begin
          if (last) begin
            cnt <= '0;
            acc <= acc ^ rx_s;
            st  <= S_STOP;
          end else cnt <= cnt + CW'(1);
        end
        S_STOP: begin
          if (last) begin
            cnt <= '0;
            if (cfg_two_stop) begin
              fe_acc <= !rx_s;
              st     <= S_STOP2;
            end else begin
              st      <= S_IDLE;
              seen_hi <= rx_s;
            end
          end else cnt <= cnt + CW'(1);
        end
        S_STOP2: begin
          if (last) begin
            cnt     <= '0;
            st      <= S_IDLE;
            seen_hi <= rx_s;
          end else cnt <= cnt + CW'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      da_q   <= 1'b0;
      pe_q   <= 1'b0;
      fe_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else if (done) begin
      data_q <= sh >> (BW'(MAXW) - nbits);
      pe_q   <= !cfg_par_off && (acc ^ !cfg_par_even);
      fe_q   <= fe_acc | !rx_s;
      ovr_q  <= da_q && ack_n;
      da_q   <= 1'b1;
    end else if (!ack_n) begin
      da_q   <= 1'b0;
    end
  end

  assign data_avail = da_q;
  assign rdata      = data_oe_n ? 'z : data_q;
  assign par_err    = stat_oe_n ? 1'bz : pe_q;
  assign frm_err    = stat_oe_n ? 1'bz : fe_q;
  assign ovr_err    = stat_oe_n ? 1'bz : ovr_q;
endmodule

// File: rtl/async_rx_chk.sv
module async_rx_chk #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          ack_n,
  input logic          done,
  input logic          da,
  input logic          ovr,
  input logic          pe,
  input logic          fe,
  input logic [W-1:0]  dq,
  input logic [2:0]    st,
  input logic [CW-1:0] cnt
);
  p_da_set_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> da);
  p_da_clr_r7: assert property (@(posedge clk) disable iff (!rst_n) (!ack_n && !done) |=> !da);
  p_ovr_set_r8: assert property (@(posedge clk) disable iff (!rst_n) (done && da && ack_n) |=> ovr);
  p_ovr_clr_r8: assert property (@(posedge clk) disable iff (!rst_n) (done && !da) |=> !ovr);
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> ($stable(dq) && $stable(pe) && $stable(fe) && $stable(ovr)));
  p_tick_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(st) && $stable(cnt)));
endmodule

bind async_rx async_rx_chk #(.W(MAXW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .ack_n(ack_n), .done(done),
  .da(da_q), .ovr(ovr_q), .pe(pe_q), .fe(fe_q), .dq(data_q), .st(st), .cnt(cnt)
);

// File: tb/async_rx_bench.sv
`timescale 1ns/1ps
module async_rx_bench;
  localparam int W = 8;
  logic clk = 0, rst_n = 0, tick = 0, rx_line = 1, ack_n = 1;
  logic data_oe_n = 0, stat_oe_n = 0;
  logic cfg_par_off = 1, cfg_par_even = 0, cfg_two_stop = 0;
  logic [1:0] cfg_len = 2'b11;
  wire [W-1:0] rdata;
  wire data_avail, par_err, frm_err, ovr_err;

  int div = 1, checks = 0, fails = 0;
  bit finished = 0;
  logic [W-1:0] e_data = '0;
  logic e_da = 0, e_pe = 0, e_fe = 0, e_ovr = 0;

  async_rx u_async_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line), .cfg_len(cfg_len),
    .cfg_par_off(cfg_par_off), .cfg_par_even(cfg_par_even), .cfg_two_stop(cfg_two_stop),
    .ack_n(ack_n), .data_oe_n(data_oe_n), .stat_oe_n(stat_oe_n), .rdata(rdata),
    .data_avail(data_avail), .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
  );

  always #2.5 clk = ~clk;

  initial begin
    int k;
    k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      if (k >= div) k = 0;
      tick = (k == 0);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R7 data_avail (R6 timing)", {31'b0, data_avail}, {31'b0, e_da});
      if (!data_oe_n) check("R3 rdata", {24'b0, rdata}, {24'b0, e_data});
      if (!stat_oe_n) begin
        check("R4 par_err", {31'b0, par_err}, {31'b0, e_pe});
        check("R5 frm_err", {31'b0, frm_err}, {31'b0, e_fe});
        check("R8 ovr_err", {31'b0, ovr_err}, {31'b0, e_ovr});
      end
    end
  end

  task automatic expect_done(input int nb_total, input logic [W-1:0] d, input logic pe, input logic fe);
    int n, t, tgt;
    n = 0; t = -1; tgt = 8 + 16 * (nb_total - 1);
    while (t != tgt) begin
      @(posedge clk);
      n++;
      if (tick) begin
        if (t >= 0) t++;
        else if (n >= 3) t = 0;
      end
    end
    #1;
    e_ovr  = e_da;
    e_da   = 1;
    e_data = d;
    e_pe   = pe;
    e_fe   = fe;
  endtask

  task automatic send(input logic [W-1:0] v, input int nb, input bit par_on, input bit even,
                      input bit two, input bit bad_par, input bit bad_stop, input bit bad_stop2);
    bit bits[$];
    int ones;
    logic [W-1:0] m;
    logic pe_x, fe_x;
    ones = 0;
    m = W'((1 << nb) - 1);
    cfg_len = 2'(nb - 5);
    cfg_par_off = !par_on;
    cfg_par_even = even;
    cfg_two_stop = two;
    bits.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      bits.push_back(v[i]);
      ones += int'(v[i]);
    end
    if (par_on) bits.push_back(bit'((ones % 2) ^ int'(!even) ^ int'(bad_par)));
    bits.push_back(!bad_stop);
    if (two) bits.push_back(!bad_stop2);
    pe_x = par_on & bad_par;
    fe_x = bad_stop | (two & bad_stop2);
    @(posedge clk); #1;
    fork
      expect_done(bits.size(), v & m, pe_x, fe_x);
    join_none
    foreach (bits[i]) begin
      rx_line = bits[i];
      repeat (16 * div) @(posedge clk);
      #1;
    end
    rx_line = 1;
    repeat (32 * div) @(posedge clk);
    #1;
  endtask

  task automatic ack();
    @(posedge clk); #1 ack_n = 0;
    @(posedge clk); #1 ack_n = 1;
    e_da = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 rdata after reset", {24'b0, rdata}, 32'h0);
    check("R1 data_avail after reset", {31'b0, data_avail}, 32'h0);
    check("R1 flags after reset", {29'b0, par_err, frm_err, ovr_err}, 32'h0);
    repeat (40) @(posedge clk);
    #1;

    send(8'hA5, 8, 0, 0, 0, 0, 0, 0);
    check("R3 8-bit data", {24'b0, rdata}, 32'hA5);
    check("R7 avail set", {31'b0, data_avail}, 32'h1);
    ack();
    @(negedge clk);
    check("R7 avail cleared by ack", {31'b0, data_avail}, 32'h0);

    send(8'h53, 7, 1, 1, 0, 0, 0, 0);
    check("R4 even parity good", {31'b0, par_err}, 32'h0);
    check("R3 7-bit data", {24'b0, rdata}, 32'h53);
    ack();

    send(8'h16, 5, 1, 0, 0, 1, 0, 0);
    check("R4 odd parity bad", {31'b0, par_err}, 32'h1);
    check("R3 5-bit data", {24'b0, rdata}, 32'h16);
    ack();

    send(8'h3C, 8, 0, 0, 0, 0, 1, 0);
    check("R5 stop at space", {31'b0, frm_err}, 32'h1);
    ack();

    send(8'h81, 8, 1, 1, 1, 0, 0, 1);
    check("R5 second stop at space", {31'b0, frm_err}, 32'h1);
    ack();
    send(8'h7E, 8, 1, 1, 1, 0, 0, 0);
    check("R9 flags replaced", {30'b0, par_err, frm_err}, 32'h0);
    ack();

    send(8'h11, 8, 0, 0, 0, 0, 0, 0);
    send(8'h22, 8, 0, 0, 0, 0, 0, 0);
    check("R8 overrun set", {31'b0, ovr_err}, 32'h1);
    check("R8 newer data kept", {24'b0, rdata}, 32'h22);
    ack();
    send(8'h33, 8, 0, 0, 0, 0, 0, 0);
    check("R8 overrun cleared", {31'b0, ovr_err}, 32'h0);
    ack();

    @(posedge clk); #1 rx_line = 0;
    repeat (4) @(posedge clk);
    #1 rx_line = 1;
    repeat (60) @(posedge clk);
    @(negedge clk);
    check("R2 false start no avail", {31'b0, data_avail}, 32'h0);
    check("R2 false start data kept", {24'b0, rdata}, 32'h33);
    send(8'h5A, 8, 0, 0, 0, 0, 0, 0);
    check("R2 start after false start", {24'b0, rdata}, 32'h5A);
    ack();

    send(8'hFF, 8, 1, 1, 0, 1, 1, 0);
    @(posedge clk); #1;
    data_oe_n = 1;
    stat_oe_n = 1;
    @(negedge clk);
    begin
      int ones_seen;
      ones_seen = 0;
      for (int i = 0; i < W; i++) if (rdata[i] === 1'b1) ones_seen++;
      check("R10 rdata released", ones_seen, 0);
    end
    check("R10 par_err released", {31'b0, par_err === 1'b1}, 32'h0);
    check("R10 frm_err released", {31'b0, frm_err === 1'b1}, 32'h0);
    check("R10 data_avail still driven", {31'b0, data_avail}, 32'h1);
    @(posedge clk); #1;
    data_oe_n = 0;
    stat_oe_n = 0;
    ack();

    div = 3;
    repeat (100) @(posedge clk);
    #1;
    send(8'hC3, 8, 1, 0, 0, 0, 0, 0);
    check("R11 divided tick data", {24'b0, rdata}, 32'hC3);
    check("R11 divided tick parity", {31'b0, par_err}, 32'h0);
    ack();
    repeat (10) @(posedge clk);

    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
    end
  end
endmodule